// File: doc/BRIEF.md
# Remote Atomic Increment Engine

This block sits between a network interface and a small single-port local memory of 32-bit semaphore words. It serves fetch-and-add requests that arrive from remote requesters. For each request it reads the target word, adds the supplied increment, and writes the sum back as one indivisible sequence. It then answers with the value the word held before the add. The response also carries the fixed byte offset at which the requester stores that returned value. Every request gets a response, including a rejected one, so a requester can treat the response as the acknowledgement that completes the operation.

Semaphore words sit one per 16-byte slot, and only the lowest word of a slot is stored. The memory therefore holds one 32-bit entry per slot, indexed by the slot number. Other agents on the tile reach the same memory through a local port. The engine holds that port off for the two memory cycles of each read-modify-write, so no local access can land between the read and the write-back.

Top module: `atomic_incr_engine`

## Requirements
- R1: A request with opcode 4'h1 and a byte address whose bits [3:0] are zero reads the word of slot addr[7:4], writes back old+increment, and responds with rsp_err=0 and rsp_old equal to the word before the add.
- R2: The sum wraps modulo 2^32; for example, 32'hFFFF_FFFF plus 2 stores 32'h0000_0001.
- R3: A request whose address has any of bits [3:0] set gets a response with rsp_err=1 and rsp_old=0, and it leaves every memory word unchanged.
- R4: A request with any opcode other than 4'h1 gets a response with rsp_err=1 and rsp_old=0, and it leaves every memory word unchanged.
- R5: Each accepted request produces exactly one response, in order. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_old and rsp_err hold their values.
- R6: req_ready falls in the cycle after a request is accepted. It stays low until the response handshake completes and rises in the cycle after that handshake.
- R7: loc_ready is low during the read cycle and the write cycle of an increment and high at every other time. A local access held off by the engine is performed once loc_ready rises and is not lost.
- R8: A local read accepted at a clock edge returns loc_rvalid=1 with the slot's word on loc_rdata in the following cycle. A local write updates the word that later requests see.
- R9: rsp_ret_addr always equals the return-slot byte offset 4.
- R10: After reset, req_ready=1, rsp_valid=0, loc_ready=1 and loc_rvalid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Atomic request present |
| req_ready | output | 1 | Engine can accept a request |
| req_opcode | input | 4 | Operation code, 4'h1 = fetch-and-add |
| req_addr | input | 8 | Target byte address |
| req_incr | input | 32 | Increment to add |
| rsp_valid | output | 1 | Response / acknowledgement present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_err | output | 1 | Request was rejected |
| rsp_old | output | 32 | Value before the increment |
| rsp_ret_addr | output | 8 | Byte offset where the requester stores rsp_old |
| loc_valid | input | 1 | Local access request |
| loc_ready | output | 1 | Local access accepted this cycle |
| loc_we | input | 1 | Local access is a write |
| loc_idx | input | 4 | Local slot index |
| loc_wdata | input | 32 | Local write data |
| loc_rvalid | output | 1 | Local read data valid |
| loc_rdata | output | 32 | Local read data |

## Verification
The hardest case to reach from the ports is a local write that arrives while an increment is between its read and its write-back. That write must be held off without being lost, and it must not be overwritten by the engine's write-back. The bench places the local write in the cycle right after a request is accepted, so it waits through the read and write cycles. The bench checks loc_ready in each of those cycles and then reads the slot back to confirm that the local value won. Response backpressure is switched on for part of the run so that the hold and ready-blocking rules are also exercised across stalled handshakes.

// File: rtl/aie_pkg.sv
package aie_pkg;
    localparam int OP_W = 4;
    localparam logic [OP_W-1:0] OP_INCR_GET = 4'h1;
    localparam int SLOT_LSB = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_RSP
    } aie_state_e;
endpackage

// File: rtl/aie_slot_mem.sv
module aie_slot_mem #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              re,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[idx];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/aie_port_arb.sv
module aie_port_arb #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_re,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              loc_valid,
    input  logic              loc_we,
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic              loc_ready,
    output logic              loc_rvalid,
    output logic              mem_re,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata
);
    logic loc_fire;
    logic rvalid_d, rvalid_q;

    // Engine owns the port for its read and write cycles; local gets it otherwise.
    assign loc_ready = !(eng_re || eng_we);
    assign loc_fire  = loc_valid && loc_ready;

    always_comb begin
        if (eng_re || eng_we) begin
            mem_re    = eng_re;
            mem_we    = eng_we;
            mem_idx   = eng_idx;
            mem_wdata = eng_wdata;
        end else begin
            mem_re    = loc_fire && !loc_we;
            mem_we    = loc_fire && loc_we;
            mem_idx   = loc_idx;
            mem_wdata = loc_wdata;
        end
        rvalid_d = loc_fire && !loc_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rvalid_d;
        end
    end

    assign loc_rvalid = rvalid_q;

    // R7: never more than one user of the memory port in a cycle
    p_single_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_fire, eng_re, eng_we}));

    // R1: the engine write-back always follows its own read in the previous cycle
    p_wr_after_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> $past(eng_re));

    // R8: read data is flagged exactly one cycle after a local read is taken
    p_rvalid_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_fire && !loc_we) |=> loc_rvalid);
endmodule

// File: rtl/aie_rmw_ctrl.sv
module aie_rmw_ctrl
    import aie_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = ADDR_W - SLOT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_opcode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_incr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_old,
    output logic              eng_re,
    output logic              eng_we,
    output logic [IDX_W-1:0]  eng_idx,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        aie_state_e        state;
        logic [IDX_W-1:0]  slot;
        logic [DATA_W-1:0] incr;
        logic [DATA_W-1:0] old;
        logic              err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  bad_req;

    assign bad_req = (req_opcode != OP_INCR_GET) || (req_addr[SLOT_LSB-1:0] != '0);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.slot = req_addr[ADDR_W-1:SLOT_LSB];
                    ctl_d.incr = req_incr;
                    ctl_d.old  = '0;
                    ctl_d.err  = bad_req;
                    ctl_d.state = bad_req ? ST_RSP : ST_RD;
                end
            end
            ST_RD: begin
                ctl_d.state = ST_WR;
            end
            ST_WR: begin
                ctl_d.old   = mem_rdata;
                ctl_d.state = ST_RSP;
            end
            ST_RSP: begin
                if (rsp_ready) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, slot: '0, incr: '0, old: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign rsp_valid = (ctl_q.state == ST_RSP);
    assign rsp_err   = ctl_q.err;
    assign rsp_old   = ctl_q.old;
    assign eng_re    = (ctl_q.state == ST_RD);
    assign eng_we    = (ctl_q.state == ST_WR);
    assign eng_idx   = ctl_q.slot;
    assign eng_wdata = mem_rdata + ctl_q.incr;

    // R6: after a request is taken the engine is busy in the next cycle
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6: requests are never accepted while a response is outstanding
    p_no_accept_during_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R5: a stalled response holds valid, value and error flag
    p_rsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old) && $stable(rsp_err)));

    // R3/R4: a rejected request reports zero as the old value
    p_err_zero_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_old == '0));
endmodule

// File: rtl/atomic_incr_engine.sv
module atomic_incr_engine
    import aie_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int RET_OFFSET = 4,
    localparam int IDX_W     = ADDR_W - SLOT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_opcode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_incr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_old,
    output logic [ADDR_W-1:0] rsp_ret_addr,
    input  logic              loc_valid,
    output logic              loc_ready,
    input  logic              loc_we,
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic              loc_rvalid,
    output logic [DATA_W-1:0] loc_rdata
);
    logic              eng_re, eng_we;
    logic [IDX_W-1:0]  eng_idx;
    logic [DATA_W-1:0] eng_wdata;
    logic              mem_re, mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    aie_rmw_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_addr(req_addr), .req_incr(req_incr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_err(rsp_err), .rsp_old(rsp_old),
        .eng_re(eng_re), .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
        .mem_rdata(mem_rdata)
    );

    aie_port_arb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .eng_re(eng_re), .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
        .loc_valid(loc_valid), .loc_we(loc_we), .loc_idx(loc_idx), .loc_wdata(loc_wdata),
        .loc_ready(loc_ready), .loc_rvalid(loc_rvalid),
        .mem_re(mem_re), .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata)
    );

    aie_slot_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .re(mem_re), .we(mem_we), .idx(mem_idx),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assign loc_rdata    = mem_rdata;
    assign rsp_ret_addr = ADDR_W'(RET_OFFSET);

    // R7: local port is refused whenever the engine is mid read-modify-write
    p_local_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !rsp_valid && (req_opcode == OP_INCR_GET)
         && (req_addr[SLOT_LSB-1:0] == '0)) |=> !loc_ready);
endmodule

// File: tb/atomic_incr_engine_bench.sv
module atomic_incr_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_opcode = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_incr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_err;
    logic [31:0] rsp_old;
    logic [7:0]  rsp_ret_addr;
    logic        loc_valid = 1'b0;
    logic        loc_ready;
    logic        loc_we = 1'b0;
    logic [3:0]  loc_idx = '0;
    logic [31:0] loc_wdata = '0;
    logic        loc_rvalid;
    logic [31:0] loc_rdata;

    always #2 clk = ~clk; // 250 MHz

    atomic_incr_engine u_atomic_incr_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_incr(req_incr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
        .rsp_old(rsp_old), .rsp_ret_addr(rsp_ret_addr),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_we(loc_we),
        .loc_idx(loc_idx), .loc_wdata(loc_wdata),
        .loc_rvalid(loc_rvalid), .loc_rdata(loc_rdata)
    );

    typedef struct packed {
        logic        err;
        logic [31:0] old;
        logic [7:0]  tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] model [16];
    int          n_checks = 0;
    int          n_errors = 0;
    logic        bp_mode = 1'b0;
    int          bp_cnt = 0;
    logic        finished = 1'b0;

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %0s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // response backpressure
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rsp_ready = bp_mode ? (bp_cnt % 3 == 0) : 1'b1;
            bp_cnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            check(req_ready == 1'b0, "R6 ready low with response out", 32'(req_ready), 32'd0);
            check(rsp_ret_addr == 8'd4, "R9 return offset", 32'(rsp_ret_addr), 32'd4);
            if (rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected response", rsp_old, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_err == e.err, $sformatf("R%0s err flag", e.tag == 8'd1 ? "1" : "3/R4"),
                          32'(rsp_err), 32'(e.err));
                    check(rsp_old == e.old, $sformatf("R%0s old value", e.tag == 8'd1 ? "1/R2" : "3/R4"),
                          rsp_old, e.old);
                end
            end
        end
    end

    task automatic loc_write(input logic [3:0] idx, input logic [31:0] val);
        @(posedge clk);
        #1;
        loc_valid = 1'b1; loc_we = 1'b1; loc_idx = idx; loc_wdata = val;
        do @(negedge clk); while (!loc_ready);
        @(posedge clk);
        #1;
        loc_valid = 1'b0; loc_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic loc_read_check(input logic [3:0] idx, input string req);
        @(posedge clk);
        #1;
        loc_valid = 1'b1; loc_we = 1'b0; loc_idx = idx;
        do @(negedge clk); while (!loc_ready);
        @(posedge clk);
        #1;
        loc_valid = 1'b0;
        @(negedge clk);
        check(loc_rvalid == 1'b1, "R8 read valid timing", 32'(loc_rvalid), 32'd1);
        check(loc_rdata == model[idx], req, loc_rdata, model[idx]);
    endtask

    task automatic send(input logic [3:0] op, input logic [7:0] addr, input logic [31:0] inc);
        exp_t e;
        logic bad;
        bad = (op != 4'h1) || (addr[3:0] != 4'h0);
        @(posedge clk);
        #1;
        req_valid = 1'b1; req_opcode = op; req_addr = addr; req_incr = inc;
        do @(negedge clk); while (!req_ready);
        e.err = bad;
        e.old = bad ? 32'd0 : model[addr[7:4]];
        e.tag = bad ? 8'd3 : 8'd1;
        exp_q.push_back(e);
        if (!bad) model[addr[7:4]] = model[addr[7:4]] + inc;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R6 ready drops after accept", 32'(req_ready), 32'd0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R6 ready back after handshake", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R5 exactly one response", 32'(rsp_valid), 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 reset req_ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check(loc_ready == 1'b1, "R10 reset loc_ready", 32'(loc_ready), 32'd1);
        check(loc_rvalid == 1'b0, "R10 reset loc_rvalid", 32'(loc_rvalid), 32'd0);

        for (int i = 0; i < 16; i++) loc_write(4'(i), 32'h1000 * (i + 1));
        loc_read_check(4'd5, "R8 local write visible");

        // R1 basic increments, repeated on one slot and across slots
        send(4'h1, 8'h30, 32'd7);
        send(4'h1, 8'h30, 32'd1);
        send(4'h1, 8'hF0, 32'd100);
        drain();
        loc_read_check(4'd3, "R1 stored sum");
        loc_read_check(4'd15, "R1 stored sum top slot");

        // R2 wrap
        loc_write(4'd2, 32'hFFFF_FFFF);
        send(4'h1, 8'h20, 32'd2);
        drain();
        loc_read_check(4'd2, "R2 wrapped sum");

        // R3 misaligned, R4 bad opcode: memory untouched
        send(4'h1, 8'h44, 32'd9);
        send(4'h1, 8'h4F, 32'd9);
        send(4'h0, 8'h40, 32'd9);
        send(4'h2, 8'h40, 32'd9);
        drain();
        loc_read_check(4'd4, "R3/R4 memory unchanged");

        // R5/R6 under backpressure
        bp_mode = 1'b1;
        send(4'h1, 8'h60, 32'd3);
        send(4'h7, 8'h60, 32'd3);
        send(4'h1, 8'h60, 32'h8000_0000);
        drain();
        loc_read_check(4'd6, "R5 sum under backpressure");
        bp_mode = 1'b0;

        // R7 local write arriving mid read-modify-write
        begin
            exp_t e;
            @(posedge clk);
            #1;
            req_valid = 1'b1; req_opcode = 4'h1; req_addr = 8'h90; req_incr = 32'd5;
            @(negedge clk);
            e.err = 1'b0; e.old = model[9]; e.tag = 8'd1;
            exp_q.push_back(e);
            @(posedge clk);
            #1;
            req_valid = 1'b0;
            loc_valid = 1'b1; loc_we = 1'b1; loc_idx = 4'd9; loc_wdata = 32'hCAFE_0009;
            @(negedge clk);
            check(loc_ready == 1'b0, "R7 local blocked in read cycle", 32'(loc_ready), 32'd0);
            @(negedge clk);
            check(loc_ready == 1'b0, "R7 local blocked in write cycle", 32'(loc_ready), 32'd0);
            @(negedge clk);
            check(loc_ready == 1'b1, "R7 local released after write-back", 32'(loc_ready), 32'd1);
            @(posedge clk);
            #1;
            loc_valid = 1'b0; loc_we = 1'b0;
            model[9] = 32'hCAFE_0009;
        end
        drain();
        loc_read_check(4'd9, "R7 held-off local write kept");

        check(exp_q.size() == 0, "R5 scoreboard empty", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule